// File: doc/BRIEF.md
# Reply Replay Buffer

This block keeps the most recent replies a target produced for control packets, so that a reply lost on the way back to the host can be sent again exactly as it was. The reply generator streams each reply into the block one 32-bit word at a time and then gives a commit strobe. The strobe carries the packet's 16-bit ID and a flag that says whether the packet was control traffic. Qualifying replies go into a fixed set of slots that behave as a shift register of records: the newest enters at slot 0 and the oldest falls off the end.

When the host asks for a resend, the first word of that request is handed to the lookup port exactly as it came off the wire, in network byte order. The block reverses its bytes and decides whether it is a resend request. If it is, the block takes the ID from the header and searches the slots from newest to oldest. It then streams the matching reply out with a valid/ready/last handshake. Outgoing words are byte-reversed into network order. A failed search gives an empty reply and a one-cycle miss flag.

A reply that arrives while a replay is streaming is held in the capture stage. It is stored only once the stream has finished, so a replay in progress never changes under the reader.

Top module: `reply_replay_buffer`

## Requirements
- R1: While reset is held and after it is released, rd_valid, rd_miss and wr_trunc are 0, and every slot is empty, so any lookup reports a miss.
- R2: A commit stores an entry only when wr_ctrl is 1 and at least one word was written since the previous commit. Any other commit discards the captured words and leaves the slots unchanged.
- R3: A lookup uses the newest stored entry whose ID equals the requested ID, even when older entries carry the same ID.
- R4: On a hit, rd_valid rises in the cycle after the lookup is accepted. The stored words come out in their original order, each with its four bytes reversed (byte 0 becomes byte 3). rd_last is 1 exactly on the final word, and rd_valid drops after that word is taken.
- R5: lk_word is accepted as a resend request only if its byte-reversed value, ANDed with 0xFF0000FF, equals 0xF2000020. The requested ID is bits 23:8 of that reversed value. Any other word on lk_valid has no effect on rd_valid or rd_miss.
- R6: The block holds SLOTS entries. Storing one more evicts the oldest, after which its ID misses unless a newer entry carries it.
- R7: On a miss, rd_miss is 1 for exactly the one cycle after the lookup is accepted, and rd_valid stays 0.
- R8: A stored reply longer than MAX_WORDS keeps only its first MAX_WORDS words. wr_trunc is 1 for the one cycle after that commit.
- R9: An entry committed while a replay is streaming does not alter that replay. It is visible to lookups made from the second cycle after the stream ends.
- R10: While rd_valid is 1 and rd_ready is 0, rd_data and rd_last hold their values and the word is not consumed.
- R11: A lookup presented while a replay is streaming is ignored. The stream continues unchanged and no miss is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Reply word present on wr_data |
| wr_data | input | 32 | Reply word, host order |
| wr_id | input | 16 | Packet ID, sampled with wr_commit |
| wr_ctrl | input | 1 | Packet is control traffic, sampled with wr_commit |
| wr_commit | input | 1 | End of the reply being captured |
| wr_trunc | output | 1 | One-cycle pulse: stored reply was truncated |
| lk_valid | input | 1 | Lookup request present on lk_word |
| lk_word | input | 32 | First request word as received, network order |
| rd_ready | input | 1 | Consumer takes the current word |
| rd_valid | output | 1 | Replay word present on rd_data |
| rd_data | output | 32 | Replay word, network order |
| rd_last | output | 1 | Current word is the last of the replay |
| rd_miss | output | 1 | One-cycle pulse: no stored reply matched |

## Verification
Several properties are checked on every cycle. Under backpressure the output word holds still, and a stream cannot be cut short before its last word is taken. A miss never comes together with valid data. A committed entry stays pending until it lands in slot 0, and the older slots move one place along at the same time. A truncation pulse only ever follows a commit. What the stored sequence contains, newest-first selection among duplicate IDs, eviction after the slots fill, header decoding and deferred visibility during a replay all depend on history. Only the bench's scenarios, run against its reference model of the slots, can show those.

// File: rtl/rrb_pkg.sv
`timescale 1ns/1ps
// Shared constants, types and helpers for the reply replay buffer.
// Assumes 32-bit words and 16-bit packet IDs throughout.
package rrb_pkg;
    localparam logic [31:0] RESEND_MASK = 32'hFF00_00FF;
    localparam logic [31:0] RESEND_CODE = 32'hF200_0020;

    typedef enum logic {
        ENG_IDLE   = 1'b0,
        ENG_STREAM = 1'b1
    } eng_state_e;

    // Reverse the four bytes of a word (host order <-> network order).
    function automatic logic [31:0] bswap32(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction
endpackage

// File: rtl/rrb_capture.sv
`timescale 1ns/1ps
// Capture stage: gathers the words of one reply, then holds it as a pending
// entry until the top lets it into the slots (apply).
// Assumes wr_valid and wr_commit never coincide, and that no new reply
// starts while an entry is still pending.
module rrb_capture #(
    parameter  int MAX_WORDS = 8,
    localparam int LEN_W     = $clog2(MAX_WORDS + 1),
    localparam int PTR_W     = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_valid,
    input  logic [31:0]             wr_data,
    input  logic [15:0]             wr_id,
    input  logic                    wr_ctrl,
    input  logic                    wr_commit,
    input  logic                    apply,
    output logic                    pend_q,
    output logic [15:0]             pend_id_q,
    output logic [LEN_W-1:0]        pend_len,
    output logic [MAX_WORDS*32-1:0] pend_words,
    output logic                    wr_trunc
);
    logic [31:0]      buf_q [MAX_WORDS];
    logic [LEN_W-1:0] cnt_q;
    logic             ovf_q;
    logic             full;

    assign full     = (cnt_q == LEN_W'(MAX_WORDS));
    assign pend_len = cnt_q;

    // Word counter, overflow flag, pending flag and truncation pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            ovf_q     <= 1'b0;
            pend_q    <= 1'b0;
            pend_id_q <= '0;
            wr_trunc  <= 1'b0;
        end else begin
            wr_trunc <= 1'b0;
            if (apply) begin
                pend_q <= 1'b0;
                cnt_q  <= '0;
                ovf_q  <= 1'b0;
            end
            if (wr_commit && !pend_q) begin
                if (wr_ctrl && cnt_q != '0) begin
                    pend_q    <= 1'b1;
                    pend_id_q <= wr_id;
                    wr_trunc  <= ovf_q;
                end else begin
                    cnt_q <= '0;
                    ovf_q <= 1'b0;
                end
            end else if (wr_valid && !pend_q) begin
                if (full) ovf_q <= 1'b1;
                else      cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // Word storage; words beyond capacity are dropped.
    always_ff @(posedge clk) begin
        if (wr_valid && !wr_commit && !pend_q && !full)
            buf_q[cnt_q[PTR_W-1:0]] <= wr_data;
    end

    for (genvar k = 0; k < MAX_WORDS; k++) begin : g_flat
        assign pend_words[k*32 +: 32] = buf_q[k];
    end

    // R9
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !apply) |=> pend_q);

    // R8
    trunc_after_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_trunc |-> $past(wr_commit));
endmodule

// File: rtl/rrb_store.sv
`timescale 1ns/1ps
// Slot array: a shift register of reply records. Slot 0 is the newest.
// A shift loads the pending entry into slot 0 and moves every record one
// place older; whatever sat in the last slot is lost.
module rrb_store #(
    parameter  int SLOTS     = 4,
    parameter  int MAX_WORDS = 8,
    localparam int LEN_W     = $clog2(MAX_WORDS + 1)
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 shift_en,
    input  logic [15:0]                          in_id,
    input  logic [LEN_W-1:0]                     in_len,
    input  logic [MAX_WORDS*32-1:0]              in_words,
    output logic [SLOTS-1:0]                     slot_vld,
    output logic [SLOTS-1:0][15:0]               slot_id,
    output logic [SLOTS-1:0][LEN_W-1:0]          slot_len,
    output logic [SLOTS-1:0][MAX_WORDS*32-1:0]   slot_data
);
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        if (s == 0) begin : g_head
            // Newest slot takes the pending entry.
            always_ff @(posedge clk) begin
                if (!rst_n)        slot_vld[s] <= 1'b0;
                else if (shift_en) slot_vld[s] <= 1'b1;
            end
            // Record payload of the newest slot.
            always_ff @(posedge clk) begin
                if (shift_en) begin
                    slot_id[s]   <= in_id;
                    slot_len[s]  <= in_len;
                    slot_data[s] <= in_words;
                end
            end
        end else begin : g_tail
            // Older slots inherit from their younger neighbour.
            always_ff @(posedge clk) begin
                if (!rst_n)        slot_vld[s] <= 1'b0;
                else if (shift_en) slot_vld[s] <= slot_vld[s-1];
            end
            // Record payload moves with the valid bit.
            always_ff @(posedge clk) begin
                if (shift_en) begin
                    slot_id[s]   <= slot_id[s-1];
                    slot_len[s]  <= slot_len[s-1];
                    slot_data[s] <= slot_data[s-1];
                end
            end
        end
    end

    // R6
    newest_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (slot_vld[0] && slot_id[0] == $past(in_id)));

    // R6
    age_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (slot_vld[SLOTS-1] == $past(slot_vld[SLOTS-2])));
endmodule

// File: rtl/rrb_search.sv
`timescale 1ns/1ps
// Newest-first ID search across the slots. Purely combinational; the
// lowest-numbered valid slot whose ID matches the key wins.
module rrb_search #(
    parameter  int SLOTS = 4,
    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic [SLOTS-1:0]       slot_vld,
    input  logic [SLOTS-1:0][15:0] slot_id,
    input  logic [15:0]            key,
    output logic                   hit,
    output logic [IDX_W-1:0]       hit_idx
);
    // Scan oldest to newest so the newest match is the last one written.
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int s = SLOTS - 1; s >= 0; s--) begin
            if (slot_vld[s] && slot_id[s] == key) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(s);
            end
        end
    end
endmodule

// File: rtl/reply_replay_buffer.sv
`timescale 1ns/1ps
// Reply replay buffer top: captures control-packet replies, keeps the last
// SLOTS of them, and replays one on a resend request in network byte order.
// Assumes the writer honours rrb_capture's ordering rules; lookups are taken
// only when no replay is streaming. Requires SLOTS >= 2, MAX_WORDS >= 2.
module reply_replay_buffer #(
    parameter int SLOTS     = 4,
    parameter int MAX_WORDS = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_valid,
    input  logic [31:0] wr_data,
    input  logic [15:0] wr_id,
    input  logic        wr_ctrl,
    input  logic        wr_commit,
    output logic        wr_trunc,
    input  logic        lk_valid,
    input  logic [31:0] lk_word,
    input  logic        rd_ready,
    output logic        rd_valid,
    output logic [31:0] rd_data,
    output logic        rd_last,
    output logic        rd_miss
);
    import rrb_pkg::*;

    localparam int LEN_W = $clog2(MAX_WORDS + 1);
    localparam int PTR_W = $clog2(MAX_WORDS);
    localparam int IDX_W = $clog2(SLOTS);

    eng_state_e                        state_q;
    logic [PTR_W-1:0]                  ptr_q;
    logic [IDX_W-1:0]                  idx_q;
    logic                              pend;
    logic [15:0]                       pend_id;
    logic [LEN_W-1:0]                  pend_len;
    logic [MAX_WORDS*32-1:0]           pend_words;
    logic [SLOTS-1:0]                  slot_vld;
    logic [SLOTS-1:0][15:0]            slot_id;
    logic [SLOTS-1:0][LEN_W-1:0]       slot_len;
    logic [SLOTS-1:0][MAX_WORDS*32-1:0] slot_data;
    logic [31:0]                       hdr;
    logic                              is_resend;
    logic                              lk_accept;
    logic                              apply;
    logic                              hit;
    logic [IDX_W-1:0]                  hit_idx;
    logic [LEN_W-1:0]                  sel_len;
    logic [31:0]                       sel_word;
    logic                              at_last;

    // Decode the request header after returning it to host order.
    assign hdr       = bswap32(lk_word);
    assign is_resend = ((hdr & RESEND_MASK) == RESEND_CODE);
    assign lk_accept = lk_valid && is_resend && (state_q == ENG_IDLE);
    // Pending entries land only while idle and no lookup is being taken.
    assign apply     = pend && (state_q == ENG_IDLE) && !lk_accept;

    rrb_capture #(.MAX_WORDS(MAX_WORDS)) u_capture (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_id(wr_id),
        .wr_ctrl(wr_ctrl), .wr_commit(wr_commit), .apply(apply),
        .pend_q(pend), .pend_id_q(pend_id), .pend_len(pend_len),
        .pend_words(pend_words), .wr_trunc(wr_trunc)
    );

    rrb_store #(.SLOTS(SLOTS), .MAX_WORDS(MAX_WORDS)) u_store (
        .clk(clk), .rst_n(rst_n), .shift_en(apply),
        .in_id(pend_id), .in_len(pend_len), .in_words(pend_words),
        .slot_vld(slot_vld), .slot_id(slot_id),
        .slot_len(slot_len), .slot_data(slot_data)
    );

    rrb_search #(.SLOTS(SLOTS)) u_search (
        .slot_vld(slot_vld), .slot_id(slot_id),
        .key(hdr[23:8]), .hit(hit), .hit_idx(hit_idx)
    );

    assign sel_len  = slot_len[idx_q];
    assign sel_word = slot_data[idx_q][ptr_q*32 +: 32];
    assign at_last  = (LEN_W'(ptr_q) == sel_len - 1'b1);

    // Replay engine: start on a hit, step on rd_ready, stop after the last word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ENG_IDLE;
            ptr_q   <= '0;
            idx_q   <= '0;
            rd_miss <= 1'b0;
        end else begin
            rd_miss <= 1'b0;
            case (state_q)
                ENG_IDLE: begin
                    if (lk_accept) begin
                        if (hit) begin
                            state_q <= ENG_STREAM;
                            idx_q   <= hit_idx;
                            ptr_q   <= '0;
                        end else begin
                            rd_miss <= 1'b1;
                        end
                    end
                end
                ENG_STREAM: begin
                    if (rd_ready) begin
                        if (at_last) state_q <= ENG_IDLE;
                        else         ptr_q   <= ptr_q + 1'b1;
                    end
                end
                default: state_q <= ENG_IDLE;
            endcase
        end
    end

    assign rd_valid = (state_q == ENG_STREAM);
    assign rd_data  = rd_valid ? bswap32(sel_word) : 32'h0;
    assign rd_last  = rd_valid && at_last;

    // R10
    hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data) && $stable(rd_last)));

    // R7
    miss_without_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_miss |-> !rd_valid);

    // R11
    stream_not_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !(rd_ready && rd_last)) |=> rd_valid);

    // R4
    stream_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_ready && rd_last) |=> !rd_valid);
endmodule

// File: tb/reply_replay_buffer_tb_top.sv
`timescale 1ns/1ps
module reply_replay_buffer_tb_top;
    import rrb_pkg::*;

    localparam int SLOTS = 4;
    localparam int MAXW  = 8;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_valid, wr_ctrl, wr_commit, wr_trunc;
    logic [31:0] wr_data;
    logic [15:0] wr_id;
    logic        lk_valid, rd_ready, rd_valid, rd_last, rd_miss;
    logic [31:0] lk_word, rd_data;

    int n_chk  = 0;
    int n_fail = 0;

    // Reference model of the slots, index 0 newest.
    bit          m_vld [SLOTS];
    logic [15:0] m_id  [SLOTS];
    int          m_len [SLOTS];
    logic [31:0] m_w   [SLOTS][MAXW];

    always #2.5 clk = ~clk;

    reply_replay_buffer #(.SLOTS(SLOTS), .MAX_WORDS(MAXW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_id(wr_id),
        .wr_ctrl(wr_ctrl), .wr_commit(wr_commit), .wr_trunc(wr_trunc),
        .lk_valid(lk_valid), .lk_word(lk_word), .rd_ready(rd_ready),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_last(rd_last),
        .rd_miss(rd_miss)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] resend_word(input logic [15:0] id);
        return bswap32(32'hF200_0020 | {8'h00, id, 8'h00});
    endfunction

    function automatic int model_find(input logic [15:0] id);
        for (int s = 0; s < SLOTS; s++)
            if (m_vld[s] && m_id[s] == id) return s;
        return -1;
    endfunction

    task automatic model_store(input logic [15:0] id, input int n, input logic [31:0] w[16]);
        for (int s = SLOTS - 1; s > 0; s--) begin
            m_vld[s] = m_vld[s-1];
            m_id[s]  = m_id[s-1];
            m_len[s] = m_len[s-1];
            for (int k = 0; k < MAXW; k++) m_w[s][k] = m_w[s-1][k];
        end
        m_vld[0] = 1'b1;
        m_id[0]  = id;
        m_len[0] = (n > MAXW) ? MAXW : n;
        for (int k = 0; k < MAXW; k++) m_w[0][k] = w[k];
    endtask

    task automatic send_reply(input logic [15:0] id, input bit ctrl, input int n,
                              input logic [31:0] w[16]);
        bit exp_tr;
        exp_tr = ctrl && (n > MAXW);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            wr_valid = 1'b1;
            wr_data  = w[k];
        end
        @(negedge clk);
        wr_valid  = 1'b0;
        wr_commit = 1'b1;
        wr_id     = id;
        wr_ctrl   = ctrl;
        @(negedge clk);
        wr_commit = 1'b0;
        check(wr_trunc === exp_tr, "R8", "trunc pulse", {31'h0, wr_trunc}, {31'h0, exp_tr});
        if (ctrl && n > 0) model_store(id, n, w);
        @(negedge clk);
        check(wr_trunc === 1'b0, "R8", "trunc width", {31'h0, wr_trunc}, 32'h0);
    endtask

    // stall_mode: 0 none, 1 random, 2 every word
    task automatic lookup(input logic [15:0] id, input int stall_mode, input bit inject,
                          input string req);
        int          e;
        int          elen;
        bit          st;
        logic [31:0] ew [MAXW];
        e    = model_find(id);
        elen = (e < 0) ? 0 : m_len[e];
        for (int k = 0; k < MAXW; k++) ew[k] = (e < 0) ? 32'h0 : m_w[e][k];
        @(negedge clk);
        lk_valid = 1'b1;
        lk_word  = resend_word(id);
        @(negedge clk);
        lk_valid = 1'b0;
        if (e < 0) begin
            check(rd_miss === 1'b1, req, "miss flag", {31'h0, rd_miss}, 32'h1);
            check(rd_valid === 1'b0, "R7", "valid on miss", {31'h0, rd_valid}, 32'h0);
            @(negedge clk);
            check(rd_miss === 1'b0, "R7", "miss width", {31'h0, rd_miss}, 32'h0);
        end else begin
            for (int k = 0; k < elen; k++) begin
                check(rd_valid === 1'b1, req, "valid", {31'h0, rd_valid}, 32'h1);
                check(rd_data === bswap32(ew[k]), req, "data", rd_data, bswap32(ew[k]));
                check(rd_last === (k == elen - 1), req, "last", {31'h0, rd_last},
                      {31'h0, (k == elen - 1)});
                if (inject && k == 0) begin
                    lk_valid = 1'b1;
                    lk_word  = resend_word(id ^ 16'h5A5A);
                end
                st = (stall_mode == 2) || (stall_mode == 1 && ($urandom % 3) == 0);
                if (st) begin
                    rd_ready = 1'b0;
                    @(negedge clk);
                    lk_valid = 1'b0;
                    check(rd_valid === 1'b1 && rd_data === bswap32(ew[k]), "R10", "held word",
                          rd_data, bswap32(ew[k]));
                    rd_ready = 1'b1;
                end
                @(negedge clk);
                lk_valid = 1'b0;
            end
            check(rd_valid === 1'b0, req, "stream end", {31'h0, rd_valid}, 32'h0);
            if (inject)
                check(rd_miss === 1'b0, "R11", "injected lookup", {31'h0, rd_miss}, 32'h0);
        end
    endtask

    task automatic fill(output logic [31:0] w[16], input logic [31:0] base);
        for (int k = 0; k < 16; k++) w[k] = base + 32'(k) * 32'h0101_0101;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] w [16];
        logic [31:0] w2 [16];
        void'($urandom(32'h1F2E3D4C));
        for (int s = 0; s < SLOTS; s++) begin
            m_vld[s] = 1'b0; m_id[s] = '0; m_len[s] = 0;
            for (int k = 0; k < MAXW; k++) m_w[s][k] = '0;
        end
        rst_n = 1'b0; wr_valid = 1'b0; wr_ctrl = 1'b0; wr_commit = 1'b0;
        wr_data = '0; wr_id = '0; lk_valid = 1'b0; lk_word = '0; rd_ready = 1'b1;
        repeat (4) @(negedge clk);
        // R1: outputs quiet in reset
        check(rd_valid === 1'b0 && rd_miss === 1'b0 && wr_trunc === 1'b0, "R1",
              "reset outputs", {29'h0, rd_valid, rd_miss, wr_trunc}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(rd_valid === 1'b0 && rd_miss === 1'b0, "R1", "after release",
              {30'h0, rd_valid, rd_miss}, 32'h0);
        lookup(16'h0000, 0, 1'b0, "R1");

        // R4: plain store and replay
        fill(w, 32'h1122_3344);
        send_reply(16'h0101, 1'b1, 3, w);
        lookup(16'h0101, 0, 1'b0, "R4");

        // R2: non-control and empty replies are not stored
        fill(w, 32'hA000_0001);
        send_reply(16'h0202, 1'b0, 3, w);
        lookup(16'h0202, 0, 1'b0, "R2");
        send_reply(16'h0303, 1'b1, 0, w);
        lookup(16'h0303, 0, 1'b0, "R2");

        // R3: newest entry with a repeated ID wins
        fill(w, 32'h0BAD_0000);
        send_reply(16'h0404, 1'b1, 2, w);
        fill(w, 32'h600D_0000);
        send_reply(16'h0404, 1'b1, 5, w);
        lookup(16'h0404, 0, 1'b0, "R3");

        // R8: long reply truncated to MAXW words
        fill(w, 32'h5500_0000);
        send_reply(16'h0505, 1'b1, 10, w);
        lookup(16'h0505, 0, 1'b0, "R8");

        // R5: wrong byte order and wrong type byte are ignored
        @(negedge clk);
        lk_valid = 1'b1;
        lk_word  = 32'hF200_0020 | (32'h0000_0505 << 8);
        @(negedge clk);
        lk_valid = 1'b0;
        check(rd_valid === 1'b0 && rd_miss === 1'b0, "R5", "host-order header",
              {30'h0, rd_valid, rd_miss}, 32'h0);
        lk_valid = 1'b1;
        lk_word  = bswap32(32'hF200_0021 | (32'h0000_0505 << 8));
        @(negedge clk);
        lk_valid = 1'b0;
        check(rd_valid === 1'b0 && rd_miss === 1'b0, "R5", "wrong type byte",
              {30'h0, rd_valid, rd_miss}, 32'h0);
        lookup(16'h0505, 0, 1'b0, "R5");

        // R6: SLOTS+1 stores evict the oldest
        for (int i = 1; i <= SLOTS + 1; i++) begin
            fill(w, 32'h6600_0000 + 32'(i));
            send_reply(16'h0600 + 16'(i), 1'b1, 2, w);
        end
        lookup(16'h0601, 0, 1'b0, "R6");
        lookup(16'h0600 + 16'(SLOTS + 1), 0, 1'b0, "R6");
        lookup(16'h0602, 0, 1'b0, "R6");

        // R10 and R11
        lookup(16'h0603, 2, 1'b0, "R10");
        lookup(16'h0604, 0, 1'b1, "R11");

        // R9: commit during a replay is deferred
        fill(w, 32'h9900_0000);
        send_reply(16'h0909, 1'b1, 8, w);
        fill(w2, 32'h9A00_0000);
        fork
            lookup(16'h0909, 2, 1'b0, "R9");
            begin
                repeat (2) @(negedge clk);
                send_reply(16'h0909, 1'b1, 2, w2);
            end
        join
        repeat (3) @(negedge clk);
        lookup(16'h0909, 0, 1'b0, "R9");

        // Random mix: R4 under varied traffic
        for (int it = 0; it < 300; it++) begin
            logic [15:0] rid;
            rid = 16'h0700 + 16'($urandom % 8);
            if (($urandom % 10) < 6) begin
                for (int k = 0; k < 16; k++) w[k] = $urandom;
                send_reply(rid, ($urandom % 4) != 0, int'($urandom % 11), w);
                repeat (2) @(negedge clk);
            end else begin
                lookup(rid, 1, 1'b0, "R4");
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule